// File: doc/BRIEF.md
# Glyph Bitmap Expansion Engine

This engine draws one text character into a linear framebuffer. When started, it reads a fixed set of words from an external command buffer. It checks the command code in word 0. From two packed vertex words it decodes the horizontal and vertical start and end positions, and it takes the foreground and background colour words from the buffer as well.

It then walks 22 glyph rows, which come from two separate word ranges of the buffer. Each row carries 16 bits. For each bit it writes one pixel, in the foreground colour if the bit is set and in the background colour if it is clear. Pixels can be 8-bit or 24-bit.

During drawing, the engine keeps a rectangle of the pixels it has touched. A display refresh stage can use this dirty rectangle to copy only the area that changed. A one-cycle done pulse marks the end of each command, whether the command was drawn or rejected.

The command buffer is a synchronous memory. The engine drives a word index with a read enable and expects the data on the next cycle. The framebuffer port takes one pixel write per cycle. The address is y·1280 + x.

Top module: `gxe_glyph_engine`

## Requirements
- R1: A command is drawn only when buffer word 0 equals 0x00000A21. Any other value produces no framebuffer write, leaves the dirty rectangle unchanged, and still raises done.
- R2: The two vertex words are buffer words 13 and 14. The foreground colour is word 16 and the background colour is word 29.
- R3: x is bits 29:19 of a vertex word, reduced modulo 1280. y is bits 12:3 of (vertex − 63) in 32-bit arithmetic, reduced modulo 1024.
- R4: The pixel count per row is x2 − x1. It is 0 when x2 ≤ x1 and is limited to 16.
- R5: The 22 rows come from words 4..11 and then 30..32. Each word gives its bits 15:0 as a row first and then its bits 31:16 as the next row. Row k lands at y = (y1 + k) mod 1024. Its pixels are written at addresses y·1280 + x1 + p for p rising from 0.
- R6: Pixel p of a row takes bit p of that row's 16 bits. A set bit gives the foreground colour and a clear bit gives the background colour.
- R7: With deep24 high, a colour word whose bits 23:16 are 0 gives 0x000000. A value of 7 gives 0xC0C0C0, and any other value gives 0xFFFFFF.
- R8: With deep24 low, the pixel is the colour word's bits 7:0 on fb_data[7:0], and fb_data[23:8] is zero.
- R9: After a drawn command, dirty_x_lo = x1 and dirty_x_hi = x2. dirty_y_lo and dirty_y_hi are the smallest and largest row y of its 22 rows, and this includes rows with zero pixels.
- R10: busy rises the cycle after start is taken. done is high for exactly one cycle after the last row. busy falls on the following cycle.
- R11: start is ignored while busy is high, and this includes the cycle in which done is high.
- R12: Under reset, fb_we, done, busy and all dirty bounds are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one command (taken when idle) |
| deep24 | input | 1 | 1: 24-bit pixels, 0: 8-bit pixels; sampled per command |
| cmd_rd_en | output | 1 | Command buffer read request |
| cmd_rd_idx | output | 6 | Command buffer word index |
| cmd_rd_data | input | 32 | Read data, valid the cycle after the request |
| fb_we | output | 1 | Framebuffer pixel write strobe |
| fb_addr | output | 21 | Linear pixel address |
| fb_data | output | 24 | Pixel value |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| dirty_x_lo | output | 11 | Dirty rectangle left edge |
| dirty_x_hi | output | 11 | Dirty rectangle right edge |
| dirty_y_lo | output | 10 | Dirty rectangle top row |
| dirty_y_hi | output | 10 | Dirty rectangle bottom row |

## Verification
Two events can land in the same cycle: a new start pulse, and the engine's own row writing or its done cycle. The bench raises start in the middle of a pixel run and again in the exact cycle done is seen. It then checks three things: the recorded write stream still matches the model of a single command, only one done pulse occurs, and busy stays low afterwards. A second overlap exists between row wrap past y = 1023 and the dirty range update. A command placed near the bottom edge provokes it, and the bench judges it by whether the dirty bounds spread to 0..1023.

// File: rtl/gxe_pkg.sv
package gxe_pkg;

  localparam logic [31:0] DRAW_CHAR_CODE = 32'h0000_0A21;
  localparam int HDR_WORDS   = 5;
  localparam int GLYPH_WORDS = 11;
  localparam int ROW_PIX     = 16;
  localparam int ROW_COUNT   = 2 * GLYPH_WORDS;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HREQ,
    ST_HCAP,
    ST_DECODE,
    ST_GREQ,
    ST_GCAP,
    ST_PIX,
    ST_ROWEND,
    ST_FIN
  } gxe_state_e;

  // header slot -> buffer word: code, vertex A, vertex B, fg, bg
  function automatic logic [5:0] hdr_word(input logic [2:0] slot);
    case (slot)
      3'd0:    return 6'd0;
      3'd1:    return 6'd13;
      3'd2:    return 6'd14;
      3'd3:    return 6'd16;
      default: return 6'd29;
    endcase
  endfunction

  // glyph slot -> buffer word: 4..11 then 30..32
  function automatic logic [5:0] glyph_word(input logic [3:0] slot);
    if (slot < 4'd8) return 6'(slot) + 6'd4;
    else             return 6'(slot) + 6'd22;
  endfunction

  function automatic logic [23:0] shade24(input logic [7:0] sel);
    if (sel == 8'd0)      return 24'h000000;
    else if (sel == 8'd7) return 24'hC0C0C0;
    else                  return 24'hFFFFFF;
  endfunction

endpackage

// File: rtl/gxe_pos_decode.sv
module gxe_pos_decode #(
  parameter int FB_W = 1280,
  parameter int FB_H = 1024,
  localparam int XW = $clog2(FB_W),
  localparam int YW = $clog2(FB_H)
) (
  input  logic [31:0]   vtx,
  output logic [XW-1:0] pos_x,
  output logic [YW-1:0] pos_y
);

  logic [31:0] biased;
  logic [10:0] x_field;
  logic [9:0]  y_field;
  logic        unused_bits;

  assign biased      = vtx - 32'd63;
  assign x_field     = vtx[29:19];
  assign y_field     = biased[12:3];
  assign unused_bits = ^{vtx[31:30], vtx[18:0], biased[31:13], biased[2:0]};

  always_comb begin
    if (32'(x_field) >= 32'(FB_W)) pos_x = XW'(32'(x_field) - 32'(FB_W));
    else                           pos_x = XW'(x_field);
    if (32'(y_field) >= 32'(FB_H)) pos_y = YW'(32'(y_field) - 32'(FB_H));
    else                           pos_y = YW'(y_field);
  end

endmodule

// File: rtl/gxe_color_map.sv
module gxe_color_map
  import gxe_pkg::*;
(
  input  logic [31:0] color_word,
  input  logic        deep,
  output logic [23:0] pix
);

  logic unused_bits;
  assign unused_bits = ^{color_word[31:24], color_word[15:8]};

  always_comb begin
    if (deep) pix = shade24(color_word[23:16]);
    else      pix = {16'h0000, color_word[7:0]};
  end

endmodule

// File: rtl/gxe_seq.sv
module gxe_seq
  import gxe_pkg::*;
#(
  parameter int FB_H = 1024,
  localparam int YW = $clog2(FB_H),
  localparam int CW = $clog2(ROW_PIX + 1),
  localparam int PW = $clog2(ROW_PIX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          deep_in,
  output logic          rd_en,
  output logic [5:0]    rd_idx,
  input  logic [31:0]   rd_data,
  input  logic [CW-1:0] pix_cnt,
  input  logic [YW-1:0] y_start,
  output logic [31:0]   hdr_v1,
  output logic [31:0]   hdr_v2,
  output logic [31:0]   hdr_fg,
  output logic [31:0]   hdr_bg,
  output logic          deep_q,
  output logic          busy,
  output logic          done,
  output logic          accept,
  output logic          pix_we,
  output logic [PW-1:0] pix_idx,
  output logic [15:0]   row_bits,
  output logic [YW-1:0] row_y,
  output logic          row_end
);

  gxe_state_e    state_q, state_d;
  logic [2:0]    h_q, h_d;
  logic [3:0]    g_q, g_d;
  logic          half_q, half_d;
  logic [PW-1:0] p_q, p_d;
  logic [YW-1:0] y_q, y_d;
  logic [31:0]   glyph_q, glyph_d;
  logic [31:0]   cmd_q, cmd_d;
  logic [31:0]   v1_q, v1_d, v2_q, v2_d, fg_q, fg_d, bg_q, bg_d;
  logic          deep_d, deep_r;
  logic          last_pix;
  logic [YW-1:0] y_next;

  assign last_pix = (CW'(p_q) + CW'(1)) == pix_cnt;

  always_comb begin
    if (32'(y_q) + 32'd1 >= 32'(FB_H)) y_next = '0;
    else                               y_next = y_q + YW'(1);
  end

  always_comb begin
    state_d = state_q;
    h_d     = h_q;
    g_d     = g_q;
    half_d  = half_q;
    p_d     = p_q;
    y_d     = y_q;
    glyph_d = glyph_q;
    cmd_d   = cmd_q;
    v1_d    = v1_q;
    v2_d    = v2_q;
    fg_d    = fg_q;
    bg_d    = bg_q;
    deep_d  = deep_r;
    rd_en   = 1'b0;
    rd_idx  = 6'd0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_HREQ;
          h_d     = 3'd0;
        end
      end
      ST_HREQ: begin
        rd_en   = 1'b1;
        rd_idx  = hdr_word(h_q);
        state_d = ST_HCAP;
      end
      ST_HCAP: begin
        case (h_q)
          3'd0:    cmd_d = rd_data;
          3'd1:    v1_d  = rd_data;
          3'd2:    v2_d  = rd_data;
          3'd3:    fg_d  = rd_data;
          default: bg_d  = rd_data;
        endcase
        if (h_q == 3'(HDR_WORDS - 1)) begin
          state_d = ST_DECODE;
        end else begin
          h_d     = h_q + 3'd1;
          state_d = ST_HREQ;
        end
      end
      ST_DECODE: begin
        if (cmd_q == DRAW_CHAR_CODE) begin
          deep_d  = deep_in;
          g_d     = 4'd0;
          y_d     = y_start;
          state_d = ST_GREQ;
        end else begin
          state_d = ST_FIN;
        end
      end
      ST_GREQ: begin
        rd_en   = 1'b1;
        rd_idx  = glyph_word(g_q);
        state_d = ST_GCAP;
      end
      ST_GCAP: begin
        glyph_d = rd_data;
        half_d  = 1'b0;
        p_d     = '0;
        state_d = (pix_cnt == '0) ? ST_ROWEND : ST_PIX;
      end
      ST_PIX: begin
        if (last_pix) state_d = ST_ROWEND;
        else          p_d     = p_q + PW'(1);
      end
      ST_ROWEND: begin
        y_d = y_next;
        p_d = '0;
        if (!half_q) begin
          half_d  = 1'b1;
          state_d = (pix_cnt == '0) ? ST_ROWEND : ST_PIX;
        end else if (g_q == 4'(GLYPH_WORDS - 1)) begin
          state_d = ST_FIN;
        end else begin
          g_d     = g_q + 4'd1;
          state_d = ST_GREQ;
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      h_q     <= '0;
      g_q     <= '0;
      half_q  <= 1'b0;
      p_q     <= '0;
      y_q     <= '0;
      glyph_q <= '0;
      cmd_q   <= '0;
      v1_q    <= '0;
      v2_q    <= '0;
      fg_q    <= '0;
      bg_q    <= '0;
      deep_r  <= 1'b0;
    end else begin
      state_q <= state_d;
      h_q     <= h_d;
      g_q     <= g_d;
      half_q  <= half_d;
      p_q     <= p_d;
      y_q     <= y_d;
      glyph_q <= glyph_d;
      cmd_q   <= cmd_d;
      v1_q    <= v1_d;
      v2_q    <= v2_d;
      fg_q    <= fg_d;
      bg_q    <= bg_d;
      deep_r  <= deep_d;
    end
  end

  assign hdr_v1   = v1_q;
  assign hdr_v2   = v2_q;
  assign hdr_fg   = fg_q;
  assign hdr_bg   = bg_q;
  assign deep_q   = deep_r;
  assign busy     = state_q != ST_IDLE;
  assign done     = state_q == ST_FIN;
  assign accept   = (state_q == ST_DECODE) && (cmd_q == DRAW_CHAR_CODE);
  assign pix_we   = state_q == ST_PIX;
  assign pix_idx  = p_q;
  assign row_bits = half_q ? glyph_q[31:16] : glyph_q[15:0];
  assign row_y    = y_q;
  assign row_end  = state_q == ST_ROWEND;

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_restart_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !(state_q == ST_HREQ && h_q == 3'd0));

  assert_pix_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_we |-> (CW'(p_q) < pix_cnt && pix_cnt <= CW'(ROW_PIX)));

endmodule

// File: rtl/gxe_dirty.sv
module gxe_dirty #(
  parameter int FB_W = 1280,
  parameter int FB_H = 1024,
  localparam int XW = $clog2(FB_W),
  localparam int YW = $clog2(FB_H)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [XW-1:0] x_first,
  input  logic [XW-1:0] x_last,
  input  logic [YW-1:0] y_first,
  input  logic          row_end,
  input  logic [YW-1:0] row_y,
  output logic [XW-1:0] x_lo,
  output logic [XW-1:0] x_hi,
  output logic [YW-1:0] y_lo,
  output logic [YW-1:0] y_hi
);

  logic [XW-1:0] xl_q, xl_d, xh_q, xh_d;
  logic [YW-1:0] yl_q, yl_d, yh_q, yh_d;

  always_comb begin
    xl_d = xl_q;
    xh_d = xh_q;
    yl_d = yl_q;
    yh_d = yh_q;
    if (accept) begin
      xl_d = x_first;
      xh_d = x_last;
      yl_d = y_first;
      yh_d = y_first;
    end else if (row_end) begin
      if (row_y < yl_q) yl_d = row_y;
      if (row_y > yh_q) yh_d = row_y;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xl_q <= '0;
      xh_q <= '0;
      yl_q <= '0;
      yh_q <= '0;
    end else begin
      xl_q <= xl_d;
      xh_q <= xh_d;
      yl_q <= yl_d;
      yh_q <= yh_d;
    end
  end

  assign x_lo = xl_q;
  assign x_hi = xh_q;
  assign y_lo = yl_q;
  assign y_hi = yh_q;

  assert_dirty_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    yl_q <= yh_q);

  assert_row_covered_R9: assert property (@(posedge clk) disable iff (!rst_n)
    row_end |=> (yl_q <= $past(row_y) && yh_q >= $past(row_y)));

endmodule

// File: rtl/gxe_glyph_engine.sv
module gxe_glyph_engine
  import gxe_pkg::*;
#(
  parameter int FB_W = 1280,
  parameter int FB_H = 1024,
  localparam int XW = $clog2(FB_W),
  localparam int YW = $clog2(FB_H),
  localparam int AW = $clog2(FB_W * FB_H + ROW_PIX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          deep24,
  output logic          cmd_rd_en,
  output logic [5:0]    cmd_rd_idx,
  input  logic [31:0]   cmd_rd_data,
  output logic          fb_we,
  output logic [AW-1:0] fb_addr,
  output logic [23:0]   fb_data,
  output logic          busy,
  output logic          done,
  output logic [XW-1:0] dirty_x_lo,
  output logic [XW-1:0] dirty_x_hi,
  output logic [YW-1:0] dirty_y_lo,
  output logic [YW-1:0] dirty_y_hi
);

  localparam int CW = $clog2(ROW_PIX + 1);
  localparam int PW = $clog2(ROW_PIX);

  logic [31:0]   vtx_w [2];
  logic [XW-1:0] vx    [2];
  logic [YW-1:0] vy    [2];
  logic [31:0]   col_w [2];
  logic [23:0]   col_p [2];

  logic [31:0]   hdr_fg, hdr_bg;
  logic          deep_q, accept, pix_we, row_end;
  logic [PW-1:0] pix_idx;
  logic [15:0]   row_bits;
  logic [YW-1:0] row_y;
  logic [CW-1:0] pix_cnt;
  logic          unused_y2;

  gxe_seq #(.FB_H(FB_H)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .deep_in  (deep24),
    .rd_en    (cmd_rd_en),
    .rd_idx   (cmd_rd_idx),
    .rd_data  (cmd_rd_data),
    .pix_cnt  (pix_cnt),
    .y_start  (vy[0]),
    .hdr_v1   (vtx_w[0]),
    .hdr_v2   (vtx_w[1]),
    .hdr_fg   (hdr_fg),
    .hdr_bg   (hdr_bg),
    .deep_q   (deep_q),
    .busy     (busy),
    .done     (done),
    .accept   (accept),
    .pix_we   (pix_we),
    .pix_idx  (pix_idx),
    .row_bits (row_bits),
    .row_y    (row_y),
    .row_end  (row_end)
  );

  assign col_w[0] = hdr_fg;
  assign col_w[1] = hdr_bg;

  for (genvar i = 0; i < 2; i++) begin : g_vtx
    gxe_pos_decode #(.FB_W(FB_W), .FB_H(FB_H)) u_pos (
      .vtx   (vtx_w[i]),
      .pos_x (vx[i]),
      .pos_y (vy[i])
    );
    gxe_color_map u_col (
      .color_word (col_w[i]),
      .deep       (deep_q),
      .pix        (col_p[i])
    );
  end

  assign unused_y2 = ^vy[1];

  always_comb begin
    if (vx[1] <= vx[0])                               pix_cnt = '0;
    else if (32'(vx[1]) - 32'(vx[0]) > 32'(ROW_PIX))  pix_cnt = CW'(ROW_PIX);
    else                                              pix_cnt = CW'(vx[1] - vx[0]);
  end

  gxe_dirty #(.FB_W(FB_W), .FB_H(FB_H)) u_dirty (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .x_first (vx[0]),
    .x_last  (vx[1]),
    .y_first (vy[0]),
    .row_end (row_end),
    .row_y   (row_y),
    .x_lo    (dirty_x_lo),
    .x_hi    (dirty_x_hi),
    .y_lo    (dirty_y_lo),
    .y_hi    (dirty_y_hi)
  );

  assign fb_we   = pix_we;
  assign fb_addr = AW'(row_y) * AW'(FB_W) + AW'(vx[0]) + AW'(pix_idx);
  assign fb_data = row_bits[pix_idx] ? col_p[0] : col_p[1];

  assert_we_in_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fb_we |-> busy);

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_we && $past(fb_we)) |-> fb_addr == $past(fb_addr) + AW'(1));

  assert_x_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (32'(vx[0]) < FB_W && 32'(vx[1]) < FB_W));

  assert_narrow_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_we && !deep_q) |-> fb_data[23:8] == 16'h0000);

endmodule

// File: tb/gxe_glyph_engine_test.sv
module gxe_glyph_engine_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        deep24 = 1'b0;
  logic        cmd_rd_en;
  logic [5:0]  cmd_rd_idx;
  logic [31:0] cmd_rd_data;
  logic        fb_we;
  logic [20:0] fb_addr;
  logic [23:0] fb_data;
  logic        busy, done;
  logic [10:0] dirty_x_lo, dirty_x_hi;
  logic [9:0]  dirty_y_lo, dirty_y_hi;

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [0:32];
  int          wcnt;
  int          dcnt;
  logic [20:0] got_addr [0:511];
  logic [23:0] got_data [0:511];

  always #2 clk = ~clk;

  gxe_glyph_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .deep24(deep24),
    .cmd_rd_en(cmd_rd_en), .cmd_rd_idx(cmd_rd_idx), .cmd_rd_data(cmd_rd_data),
    .fb_we(fb_we), .fb_addr(fb_addr), .fb_data(fb_data),
    .busy(busy), .done(done),
    .dirty_x_lo(dirty_x_lo), .dirty_x_hi(dirty_x_hi),
    .dirty_y_lo(dirty_y_lo), .dirty_y_hi(dirty_y_hi)
  );

  always @(posedge clk) begin
    if (cmd_rd_en && cmd_rd_idx <= 6'd32) cmd_rd_data <= mem[cmd_rd_idx];
    else                                  cmd_rd_data <= 32'h0;
  end

  always @(negedge clk) begin
    if (fb_we) begin
      if (wcnt < 512) begin
        got_addr[wcnt] = fb_addr;
        got_data[wcnt] = fb_data;
      end
      wcnt = wcnt + 1;
    end
    if (done) dcnt = dcnt + 1;
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    errors = errors + 1;
    $display("FAIL watchdog: run did not finish (actual hung, expected end)");
    summary();
  end

  function automatic int dec_x(input logic [31:0] v);
    int x = int'(v[29:19]);
    return (x >= 1280) ? x - 1280 : x;
  endfunction

  function automatic int dec_y(input logic [31:0] v);
    logic [31:0] b = v - 32'd63;
    return int'(b[12:3]) % 1024;
  endfunction

  function automatic logic [23:0] colr(input logic [31:0] w, input logic d);
    if (!d) return {16'h0, w[7:0]};
    if (w[23:16] == 8'd0) return 24'h000000;
    if (w[23:16] == 8'd7) return 24'hC0C0C0;
    return 24'hFFFFFF;
  endfunction

  function automatic logic [31:0] mkv(input int x, input int y);
    return (32'(x) << 19) + (32'(y) << 3) + 32'd63;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // restart: 1 = pulse start mid-run and on the done cycle
  task automatic run_cmd(input logic d, input bit restart);
    int n;
    deep24 = d;
    wcnt = 0;
    dcnt = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10", "busy after start", busy, 1);
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
      if (restart && n == 60) start = 1'b1;
      else start = 1'b0;
    end
    if (restart) begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end else begin
      @(negedge clk);
    end
    chk(busy == 1'b0, "R10", "busy low after done", busy, 0);
    for (int k = 0; k < 20; k++) @(negedge clk);
    chk(dcnt == 1 && busy == 1'b0, "R11", "done count / idle", dcnt, 1);
  endtask

  task automatic expect_draw(input logic d, input string tag);
    int x1, x2, y1, n, idx, exp_cnt, bad, ylo, yhi, y;
    logic [15:0] bits;
    logic [20:0] ea;
    logic [23:0] ed;
    x1 = dec_x(mem[13]);
    x2 = dec_x(mem[14]);
    y1 = dec_y(mem[13]);
    n  = (x2 <= x1) ? 0 : ((x2 - x1 > 16) ? 16 : x2 - x1);
    exp_cnt = 22 * n;
    chk(wcnt == exp_cnt, "R4", {tag, " write count"}, wcnt, exp_cnt);
    bad = 0;
    idx = 0;
    ylo = y1;
    yhi = y1;
    for (int k = 0; k < 22; k++) begin
      int gw = k / 2;
      int wi = (gw < 8) ? 4 + gw : 22 + gw;
      bits = (k % 2) ? mem[wi][31:16] : mem[wi][15:0];
      y = (y1 + k) % 1024;
      if (y < ylo) ylo = y;
      if (y > yhi) yhi = y;
      for (int p = 0; p < n; p++) begin
        ea = 21'(y * 1280 + x1 + p);
        ed = bits[p] ? colr(mem[16], d) : colr(mem[29], d);
        if (idx < wcnt && bad == 0 &&
            (got_addr[idx] != ea || got_data[idx] != ed)) begin
          bad = 1;
          $display("FAIL R5/R6 %s pixel %0d: actual %0h/%0h expected %0h/%0h",
                   tag, idx, got_addr[idx], got_data[idx], ea, ed);
        end
        idx++;
      end
    end
    checks = checks + 1;
    if (bad) errors = errors + 1;
    chk(int'(dirty_x_lo) == x1 && int'(dirty_x_hi) == x2, "R9",
        {tag, " dirty x"}, {dirty_x_lo, dirty_x_hi}, {11'(x1), 11'(x2)});
    chk(int'(dirty_y_lo) == ylo && int'(dirty_y_hi) == yhi, "R9",
        {tag, " dirty y"}, {dirty_y_lo, dirty_y_hi}, {10'(ylo), 10'(yhi)});
  endtask

  task automatic fill(input int x1, input int y1, input int x2,
                      input logic [31:0] fg, input logic [31:0] bg);
    for (int i = 0; i <= 32; i++) mem[i] = $urandom();
    mem[0]  = 32'h0000_0A21;
    mem[13] = mkv(x1, y1);
    mem[14] = mkv(x2, y1 + 11);
    mem[16] = fg;
    mem[29] = bg;
  endtask

  initial begin
    logic [10:0] sx_lo, sx_hi;
    logic [9:0]  sy_lo, sy_hi;
    void'($urandom(32'd20240601));
    wcnt = 0;
    dcnt = 0;
    for (int i = 0; i <= 32; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(fb_we == 0 && done == 0 && busy == 0, "R12", "reset controls",
        {fb_we, done, busy}, 0);
    chk(dirty_x_lo == 0 && dirty_x_hi == 0 && dirty_y_lo == 0 && dirty_y_hi == 0,
        "R12", "reset dirty", {dirty_x_lo, dirty_y_lo}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R6 R7: full row, white on black at 24-bit
    fill(100, 200, 116, 32'h00FF_0000, 32'h0000_00AA);
    run_cmd(1'b1, 1'b0);
    expect_draw(1'b1, "R7 full row");

    // R7 grey foreground
    fill(640, 500, 656, 32'h0007_0000, 32'h0033_0000);
    run_cmd(1'b1, 1'b0);
    expect_draw(1'b1, "R7 grey");

    // R8 8-bit depth
    fill(20, 10, 36, 32'h0007_005A, 32'h00FF_00C3);
    run_cmd(1'b0, 1'b0);
    expect_draw(1'b0, "R8 narrow");

    // R4 clamp to 16 and short row
    fill(300, 300, 340, 32'h0001_0000, 32'h0);
    run_cmd(1'b1, 1'b0);
    expect_draw(1'b1, "R4 clamp");
    fill(300, 300, 305, 32'h0001_0000, 32'h0);
    run_cmd(1'b0, 1'b0);
    expect_draw(1'b0, "R4 short");

    // R4 R9 empty rows still track dirty y
    fill(400, 50, 390, 32'h0001_0000, 32'h0);
    run_cmd(1'b1, 1'b0);
    expect_draw(1'b1, "R9 empty rows");

    // R3 x wrap: field 1500 -> 220
    fill(1500, 60, 1510, 32'h0001_0000, 32'h0);
    run_cmd(1'b1, 1'b0);
    expect_draw(1'b1, "R3 x wrap");

    // R3 borrow through the -63 bias
    fill(10, 0, 20, 32'h0001_0000, 32'h0);
    mem[13] = (32'd10 << 19) | 32'd5;
    run_cmd(1'b1, 1'b0);
    expect_draw(1'b1, "R3 y borrow");

    // R5 R9 row wrap at the bottom edge
    fill(30, 1015, 40, 32'h0001_0000, 32'h0);
    run_cmd(1'b0, 1'b0);
    expect_draw(1'b0, "R5 y wrap");

    // R1 rejected code: no writes, dirty unchanged, done once
    sx_lo = dirty_x_lo; sx_hi = dirty_x_hi; sy_lo = dirty_y_lo; sy_hi = dirty_y_hi;
    fill(700, 700, 716, 32'h0001_0000, 32'h0);
    mem[0] = 32'h0000_0A20;
    run_cmd(1'b1, 1'b0);
    chk(wcnt == 0, "R1", "rejected writes", wcnt, 0);
    chk(dirty_x_lo == sx_lo && dirty_x_hi == sx_hi && dirty_y_lo == sy_lo &&
        dirty_y_hi == sy_hi, "R1", "rejected dirty", {dirty_x_lo, dirty_y_lo},
        {sx_lo, sy_lo});

    // R11 start during pixels and on the done cycle
    fill(900, 400, 916, 32'h0007_0000, 32'h00FF_0000);
    run_cmd(1'b1, 1'b1);
    expect_draw(1'b1, "R11 restart");

    // random mix
    for (int t = 0; t < 16; t++) begin
      int rx = int'($urandom_range(1900, 0));
      int ry = int'($urandom_range(1023, 0));
      int rw = int'($urandom_range(24, 0));
      logic rd = 1'($urandom_range(1, 0));
      logic [31:0] fgw = $urandom();
      logic [31:0] bgw = $urandom();
      if (t % 4 == 0) fgw[23:16] = 8'd7;
      if (t % 4 == 1) bgw[23:16] = 8'd0;
      fill(rx, ry, rx + rw, fgw, bgw);
      mem[13] = mem[13] ^ ($urandom() & 32'hC007_0007);
      run_cmd(rd, t % 5 == 0);
      expect_draw(rd, "R6 random");
    end

    summary();
  end

endmodule